// File: doc/BRIEF.md
# USB Controller Register Wrapper with Alias Window

This block is a memory-mapped slave placed in front of an embedded USB controller core. Each bus request carries an offset, a direction and a size (byte, halfword or word). The wrapper sorts the offset into one of three regions. The low region is handed to the core port with its address untouched. The middle region is an alias window that is folded into a small set of core offsets. The top region is a bank of wrapper configuration registers that the wrapper holds itself.

The configuration bank holds a fixed revision value and a fixed status value. It also holds a masked system configuration word, an interface selector, a simulation enable bit and a standby force bit. When a system configuration write has its soft-reset bit set, every bank register first returns to its reset value, and then the masked write value is stored. Read data comes back one clock after the request from whichever source served it. A one-cycle error pulse with a code marks a write to a read-only register or an access to an offset the bank does not decode. The core interrupt level is passed straight to the interrupt output.

Top module: `usbw_wrap`

## Requirements
- R1: A request with offset below 0x200 drives the core port in the same cycle with the same address, direction, size and write data.
- R2: A request with offset from 0x200 to 0x3FF drives the core port at address 0x20 + ((offset >> 3) AND 0x3C), with the same direction, size and write data.
- R3: Every read raises rsp_valid for exactly the following cycle, and rsp_rdata then carries the core read data or the local register value. A write produces no response.
- R4: A word read at 0x400 returns 0, and a word read at 0x408 always returns 1.
- R5: A word write to 0x404 stores only the bits selected by mask 0x301F, and these bits read back at 0x404.
- R6: When bit 1 of the data written to 0x404 is set, all bank registers first take their reset values, and then the masked data is stored at 0x404.
- R7: After reset, the bank reads 0 at 0x404, 1 at 0x40C, 0 at 0x410 and 1 at 0x414.
- R8: A write to 0x40C keeps bits [1:0] only. Writes to 0x410 and to 0x414 each keep bit 0 only.
- R9: A word write to 0x400 or to 0x408 changes nothing and produces err_valid for one cycle with err_code 1 (read-only).
- R10: Several accesses at 0x400 and above read 0, write nothing and produce err_valid for one cycle with err_code 2 (bad register). These are an access to any undecoded offset, an access with a size other than word (req_size 2), and an access whose offset is not word-aligned. Size codes are 0 for byte, 1 for halfword and 2 for word.
- R11: ctrl_irq equals core_irq_in at all times.
- R12: A request at offset 0x400 or above never asserts core_valid. Legal requests in any region leave err_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| core_valid | output | 1 | Core port request strobe |
| core_write | output | 1 | Core port direction |
| core_size | output | 2 | Core port access size |
| core_addr | output | ADDR_W | Core port address after remap |
| core_wdata | output | 32 | Core port write data |
| core_rdata | input | 32 | Core read data, due one cycle after core_valid |
| core_irq_in | input | 1 | Core interrupt level |
| ctrl_irq | output | 1 | Controller interrupt output |
| err_valid | output | 1 | One-cycle access error pulse |
| err_code | output | 2 | 0 none, 1 read-only, 2 bad register |

## Verification
The core port fields and the interrupt output are combinational, so the bench reads them in the same cycle as the request, shortly after driving it on the falling edge. Read data, rsp_valid and the error pulse come out of one register stage. The bench samples them on the falling edge after the next rising edge and checks that the pulse is gone one cycle later. Local register state is read back with word reads through the same path, right after each write or rejected access that could have changed it.

// File: rtl/usbw_pkg.sv
package usbw_pkg;

    typedef enum logic [1:0] {
        RGN_DIRECT = 2'd0,
        RGN_ALIAS  = 2'd1,
        RGN_LOCAL  = 2'd2
    } rgn_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_RDONLY = 2'd1,
        ERR_BADREG = 2'd2
    } err_e;

    localparam logic [31:0] ALIAS_BASE = 32'h200;
    localparam logic [31:0] LOCAL_BASE = 32'h400;

    localparam logic [31:0] OFS_REV    = 32'h400;
    localparam logic [31:0] OFS_SYSCFG = 32'h404;
    localparam logic [31:0] OFS_STAT   = 32'h408;
    localparam logic [31:0] OFS_IFSEL  = 32'h40C;
    localparam logic [31:0] OFS_SIMEN  = 32'h410;
    localparam logic [31:0] OFS_STDBY  = 32'h414;

    localparam logic [31:0] REV_VALUE   = 32'h0;
    localparam logic [31:0] STAT_VALUE  = 32'h1;
    localparam logic [31:0] SYSCFG_MASK = 32'h301F;
    localparam int          SOFTRST_BIT = 1;
    localparam int          SYSCFG_W    = 14;

    typedef struct packed {
        logic [SYSCFG_W-1:0] syscfg;
        logic [1:0]          ifsel;
        logic                simen;
        logic                stdby;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{syscfg: '0, ifsel: 2'd1, simen: 1'b0, stdby: 1'b1};

    // Fold an alias-window offset onto a core register offset.
    function automatic logic [31:0] alias_fold(input logic [31:0] ofs);
        return 32'h20 + ((ofs >> 3) & 32'h3C);
    endfunction

endpackage

// File: rtl/usbw_region_dec.sv
module usbw_region_dec
    import usbw_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output rgn_e              region,
    output logic [ADDR_W-1:0] core_addr
);
    logic [31:0] ofs;

    always_comb begin
        ofs = 32'(addr);
        if (ofs < ALIAS_BASE) begin
            region    = RGN_DIRECT;
            core_addr = addr;
        end else if (ofs < LOCAL_BASE) begin
            region    = RGN_ALIAS;
            core_addr = ADDR_W'(alias_fold(ofs));
        end else begin
            region    = RGN_LOCAL;
            core_addr = '0;
        end
    end
endmodule

// File: rtl/usbw_cfg_bank.sv
module usbw_cfg_bank
    import usbw_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [1:0]        acc_size,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       rd_data,
    output err_e              err
);
    cfg_t        cfg_q, cfg_d;
    logic [31:0] ofs;
    logic        word_ok;
    logic        wr_ok;

    assign ofs     = 32'(acc_addr);
    assign word_ok = (acc_size == SZ_WORD) && (ofs[1:0] == 2'b00);
    assign wr_ok   = acc_en && acc_wr && word_ok;

    // Read mux and error classification.
    always_comb begin
        rd_data = '0;
        err     = ERR_NONE;
        if (acc_en) begin
            if (!word_ok) begin
                err = ERR_BADREG;
            end else begin
                unique case (ofs)
                    OFS_REV: begin
                        rd_data = REV_VALUE;
                        if (acc_wr) err = ERR_RDONLY;
                    end
                    OFS_STAT: begin
                        rd_data = STAT_VALUE;
                        if (acc_wr) err = ERR_RDONLY;
                    end
                    OFS_SYSCFG: rd_data = 32'(cfg_q.syscfg);
                    OFS_IFSEL:  rd_data = 32'(cfg_q.ifsel);
                    OFS_SIMEN:  rd_data = 32'(cfg_q.simen);
                    OFS_STDBY:  rd_data = 32'(cfg_q.stdby);
                    default:    err = ERR_BADREG;
                endcase
            end
        end
    end

    // Next state: soft reset first, then the masked store.
    always_comb begin
        cfg_d = cfg_q;
        if (wr_ok) begin
            case (ofs)
                OFS_SYSCFG: begin
                    if (acc_wdata[SOFTRST_BIT]) cfg_d = CFG_RESET;
                    cfg_d.syscfg = SYSCFG_W'(acc_wdata & SYSCFG_MASK);
                end
                OFS_IFSEL: cfg_d.ifsel = acc_wdata[1:0];
                OFS_SIMEN: cfg_d.simen = acc_wdata[0];
                OFS_STDBY: cfg_d.stdby = acc_wdata[0];
                default:   cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= CFG_RESET;
        else     cfg_q <= cfg_d;
    end
endmodule

// File: rtl/usbw_wrap.sv
module usbw_wrap
    import usbw_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              core_valid,
    output logic              core_write,
    output logic [1:0]        core_size,
    output logic [ADDR_W-1:0] core_addr,
    output logic [31:0]       core_wdata,
    input  logic [31:0]       core_rdata,
    input  logic              core_irq_in,
    output logic              ctrl_irq,
    output logic              err_valid,
    output logic [1:0]        err_code
);
    rgn_e        region;
    logic [31:0] loc_rd;
    err_e        loc_err;
    logic        loc_en;

    logic        rsp_valid_q;
    logic        from_core_q;
    logic [31:0] loc_rd_q;
    logic        err_valid_q;
    err_e        err_code_q;

    usbw_region_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (req_addr),
        .region    (region),
        .core_addr (core_addr)
    );

    assign loc_en = req_valid && (region == RGN_LOCAL);

    usbw_cfg_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .acc_en    (loc_en),
        .acc_wr    (req_write),
        .acc_size  (req_size),
        .acc_addr  (req_addr),
        .acc_wdata (req_wdata),
        .rd_data   (loc_rd),
        .err       (loc_err)
    );

    assign core_valid = req_valid && (region != RGN_LOCAL);
    assign core_write = req_write;
    assign core_size  = req_size;
    assign core_wdata = req_wdata;
    assign ctrl_irq   = core_irq_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            from_core_q <= 1'b0;
            loc_rd_q    <= '0;
            err_valid_q <= 1'b0;
            err_code_q  <= ERR_NONE;
        end else begin
            rsp_valid_q <= req_valid && !req_write;
            from_core_q <= core_valid;
            loc_rd_q    <= loc_rd;
            err_valid_q <= loc_en && (loc_err != ERR_NONE);
            err_code_q  <= loc_en ? loc_err : ERR_NONE;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = from_core_q ? core_rdata : loc_rd_q;
    assign err_valid = err_valid_q;
    assign err_code  = err_code_q;
endmodule

// File: rtl/usbw_wrap_chk.sv
module usbw_wrap_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              core_valid,
    input logic [ADDR_W-1:0] core_addr,
    input logic              core_irq_in,
    input logic              ctrl_irq,
    input logic              err_valid,
    input logic [1:0]        err_code
);
    // R1
    direct_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && 32'(req_addr) < 32'h200) |-> (core_valid && core_addr == req_addr));

    // R2
    alias_range_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && 32'(req_addr) >= 32'h200 && 32'(req_addr) < 32'h400)
        |-> (core_valid && core_addr[1:0] == 2'b00
             && 32'(core_addr) >= 32'h20 && 32'(core_addr) <= 32'h5C));

    // R3
    read_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    // R3
    write_norsp_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> !rsp_valid);

    // R9
    rdonly_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_size == 2'd2
         && (32'(req_addr) == 32'h400 || 32'(req_addr) == 32'h408))
        |=> (err_valid && err_code == 2'd1));

    // R10
    err_code_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (err_code == 2'd1 || err_code == 2'd2));

    // R11
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_irq == core_irq_in);

    // R12
    local_iso_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && 32'(req_addr) >= 32'h400) |-> !core_valid);
endmodule

bind usbw_wrap usbw_wrap_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_size    (req_size),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .core_valid  (core_valid),
    .core_addr   (core_addr),
    .core_irq_in (core_irq_in),
    .ctrl_irq    (ctrl_irq),
    .err_valid   (err_valid),
    .err_code    (err_code)
);

// File: tb/usbw_wrap_tb.sv
module usbw_wrap_tb;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_write;
    logic [1:0]        req_size;
    logic [ADDR_W-1:0] req_addr;
    logic [31:0]       req_wdata;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic              core_valid;
    logic              core_write;
    logic [1:0]        core_size;
    logic [ADDR_W-1:0] core_addr;
    logic [31:0]       core_wdata;
    logic [31:0]       core_rdata;
    logic              core_irq_in;
    logic              ctrl_irq;
    logic              err_valid;
    logic [1:0]        err_code;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    usbw_wrap #(.ADDR_W(ADDR_W)) u_dut (.*);

    // Core model: register array with one-cycle read latency.
    logic [31:0] cmem   [0:511];
    logic [31:0] shadow [0:511];
    always @(posedge clk) begin
        if (core_valid && core_write) cmem[core_addr[8:0]] <= core_wdata;
        if (core_valid && !core_write) core_rdata <= cmem[core_addr[8:0]];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] fold(input logic [31:0] a);
        return 32'h20 + ((a >> 3) & 32'h3C);
    endfunction

    // Observed results of one access.
    logic              o_cv, o_cw, o_rv, o_ev;
    logic [1:0]        o_cs, o_ec;
    logic [ADDR_W-1:0] o_ca;
    logic [31:0]       o_cd, o_rd;

    task automatic access(input bit wr, input logic [1:0] sz, input logic [ADDR_W-1:0] a,
                          input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
        #1;
        o_cv = core_valid; o_cw = core_write; o_cs = core_size; o_ca = core_addr; o_cd = core_wdata;
        @(negedge clk);
        o_rv = rsp_valid; o_rd = rsp_rdata; o_ev = err_valid; o_ec = err_code;
        req_valid = 1'b0;
        @(negedge clk);
        chk(!rsp_valid && !err_valid, "R3 pulse length", {30'd0, rsp_valid, err_valid}, 32'd0);
    endtask

    task automatic rd_local(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        access(1'b0, 2'd2, a, 32'd0);
        chk(o_rv && o_rd == exp, tag, o_rd, exp);
        chk(!o_ev, "R12 no error on legal read", {30'd0, o_ec}, 32'd0);
    endtask

    task automatic wr_local(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        access(1'b1, 2'd2, a, d);
        chk(!o_ev && !o_rv, "R12 legal write quiet", {30'd0, o_ec}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 512; i++) begin
            cmem[i]   = 32'hC0DE_0000 ^ (i * 32'h0001_0203);
            shadow[i] = 32'hC0DE_0000 ^ (i * 32'h0001_0203);
        end
        rst = 1'b1; req_valid = 0; req_write = 0; req_size = 0; req_addr = '0; req_wdata = '0;
        core_irq_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk(!rsp_valid && !err_valid, "R7 outputs idle after reset", {30'd0, rsp_valid, err_valid}, 0);

        // R7 reset values, R4 fixed values
        rd_local(12'h404, 32'h0, "R7 syscfg reset");
        rd_local(12'h40C, 32'h1, "R7 ifsel reset");
        rd_local(12'h410, 32'h0, "R7 simen reset");
        rd_local(12'h414, 32'h1, "R7 stdby reset");
        rd_local(12'h400, 32'h0, "R4 revision");
        rd_local(12'h408, 32'h1, "R4 status");

        // R1 direct window, random
        for (int i = 0; i < 40; i++) begin
            logic [ADDR_W-1:0] a = ADDR_W'($urandom_range(0, 32'h1FF));
            logic [1:0] sz = 2'($urandom_range(0, 2));
            logic [31:0] d = $urandom;
            bit wr = 1'($urandom_range(0, 1));
            access(wr, sz, a, d);
            chk(o_cv && o_ca == a && o_cw == wr && o_cs == sz, "R1 passthrough addr",
                32'(o_ca), 32'(a));
            if (wr) begin
                chk(o_cd == d, "R1 write data", o_cd, d);
                shadow[a[8:0]] = d;
            end else begin
                chk(o_rv && o_rd == shadow[a[8:0]], "R3 direct read data", o_rd, shadow[a[8:0]]);
            end
            chk(!o_ev, "R12 no error direct", {30'd0, o_ec}, 0);
        end

        // R2 alias window, random plus edges
        for (int i = 0; i < 40; i++) begin
            logic [ADDR_W-1:0] a;
            logic [31:0] d = $urandom;
            logic [31:0] t;
            bit wr = 1'($urandom_range(0, 1));
            if (i == 0) a = 12'h200;
            else if (i == 1) a = 12'h3FF;
            else a = ADDR_W'($urandom_range(32'h200, 32'h3FF));
            t = fold(32'(a));
            access(wr, 2'd2, a, d);
            chk(o_cv && 32'(o_ca) == t && o_cw == wr, "R2 alias remap", 32'(o_ca), t);
            if (wr) shadow[t[8:0]] = d;
            else chk(o_rv && o_rd == shadow[t[8:0]], "R3 alias read data", o_rd, shadow[t[8:0]]);
        end

        // R12 local access keeps core idle
        access(1'b0, 2'd2, 12'h40C, 0);
        chk(!o_cv, "R12 core idle on local", {31'd0, o_cv}, 0);

        // R5 mask
        wr_local(12'h404, 32'hFFFF_FFFD);
        rd_local(12'h404, 32'h0000_301D, "R5 syscfg mask");

        // R8 field masks
        wr_local(12'h40C, 32'hFF);
        rd_local(12'h40C, 32'h3, "R8 ifsel mask");
        wr_local(12'h410, 32'hFE);
        rd_local(12'h410, 32'h0, "R8 simen bit0 only");
        wr_local(12'h410, 32'h3);
        rd_local(12'h410, 32'h1, "R8 simen set");
        wr_local(12'h414, 32'hFFFE);
        rd_local(12'h414, 32'h0, "R8 stdby bit0 only");

        // R6 soft reset
        wr_local(12'h404, 32'h0000_0002);
        rd_local(12'h404, 32'h2, "R6 syscfg after soft reset");
        rd_local(12'h40C, 32'h1, "R6 ifsel restored");
        rd_local(12'h410, 32'h0, "R6 simen restored");
        rd_local(12'h414, 32'h1, "R6 stdby restored");
        wr_local(12'h40C, 32'h2);
        wr_local(12'h404, 32'hFFFF_1003);
        rd_local(12'h404, 32'h1003, "R6 masked store after reset");
        rd_local(12'h40C, 32'h1, "R6 ifsel reset again");

        // R9 read-only
        access(1'b1, 2'd2, 12'h400, 32'h55);
        chk(o_ev && o_ec == 2'd1, "R9 revision write flagged", {30'd0, o_ec}, 1);
        rd_local(12'h400, 32'h0, "R9 revision unchanged");
        access(1'b1, 2'd2, 12'h408, 32'h0);
        chk(o_ev && o_ec == 2'd1, "R9 status write flagged", {30'd0, o_ec}, 1);
        rd_local(12'h408, 32'h1, "R9 status unchanged");

        // R10 bad register cases
        access(1'b0, 2'd2, 12'h418, 0);
        chk(o_ev && o_ec == 2'd2, "R10 undefined read flagged", {30'd0, o_ec}, 2);
        chk(o_rv && o_rd == 0, "R10 undefined reads zero", o_rd, 0);
        access(1'b1, 2'd2, 12'h7FC, 32'hFFFF_FFFF);
        chk(o_ev && o_ec == 2'd2, "R10 undefined write flagged", {30'd0, o_ec}, 2);
        access(1'b0, 2'd0, 12'h40C, 0);
        chk(o_ev && o_ec == 2'd2 && o_rd == 0, "R10 byte read local", o_rd, 0);
        access(1'b1, 2'd1, 12'h40C, 32'h0);
        chk(o_ev && o_ec == 2'd2, "R10 halfword write flagged", {30'd0, o_ec}, 2);
        rd_local(12'h40C, 32'h1, "R10 ifsel untouched by halfword");
        access(1'b1, 2'd2, 12'h40E, 32'h0);
        chk(o_ev && o_ec == 2'd2, "R10 misaligned write flagged", {30'd0, o_ec}, 2);
        rd_local(12'h40C, 32'h1, "R10 ifsel untouched by misaligned");

        // R11 interrupt follow
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            core_irq_in = 1'(i % 2 == 0);
            #1;
            chk(ctrl_irq == core_irq_in, "R11 irq follow", {31'd0, ctrl_irq}, {31'd0, core_irq_in});
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule